// File: doc/BRIEF.md
# Strip-Mined Vector Loop Sequencer

This block runs a vector loop whose element count is only known at run time. A one-cycle start pulse captures the count `n`. The block then hands a vector unit a series of chunk commands over a valid/ready handshake. Each command carries a start index and a vector length. The first command covers the odd-sized remainder, `n` modulo the maximum vector length. Every command after it covers a full maximum-length strip, and each start index follows on from the end of the previous chunk. When `n` is an exact multiple of the maximum length, the first command has length zero. The loop still completes normally.

The block also holds a per-element vector mask. A compare port writes one mask bit per cycle. The bit is 1 when the presented element differs from the presented scalar. An element-write port then passes a write through to the datapath only where the mask bit is set and the element index lies inside the current vector length. The current vector length is taken from the most recently accepted chunk command. The element datapath and memory sit outside the block.

Top module: `strip_loop_seq`

## Requirements
- R1: After an accepted start, the first chunk command has start index 0 and length `n % MAX_VL` (MAX_VL = 64 by default), including length 0 when `n` is a multiple of MAX_VL.
- R2: Every chunk command after the first has length MAX_VL, and its start index equals the previous start index plus the previous length.
- R3: Exactly `n / MAX_VL + 1` chunk commands are accepted per loop (integer division). For `n = 0`, this is a single zero-length chunk.
- R4: While `cmd_valid_o` is high and `cmd_ready_i` is low, `cmd_valid_o`, `cmd_base_o` and `cmd_len_o` hold their values.
- R5: `vl_o` resets to 0. In the cycle after a chunk handshake, it equals the length of the accepted chunk.
- R6: `done_o` is high for exactly one cycle, the cycle after the last chunk handshake. In that cycle `busy_o` is low.
- R7: A start pulse while `busy_o` is high is ignored. The command sequence in progress continues unchanged.
- R8: `mask_o` resets to all zeros. A compare at index i sets bit i to 1 if `cmp_elem_i != cmp_scalar_i` and to 0 otherwise, visible the next cycle. All other bits keep their values.
- R9: An element write at index i with mask bit i set and i < `vl_o` produces `wr_en_o` = 1 in the next cycle, with the same index and data on `wr_idx_o` and `wr_data_o`.
- R10: An element write whose mask bit is 0, or whose index is at or beyond `vl_o`, produces `wr_en_o` = 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| n_i | input | CNT_W | Total element count, sampled with the start pulse |
| busy_o | output | 1 | High while chunk commands remain to be accepted |
| done_o | output | 1 | One-cycle pulse after the final chunk handshake |
| cmd_valid_o | output | 1 | A chunk command is offered |
| cmd_ready_i | input | 1 | The vector unit accepts the offered command |
| cmd_base_o | output | CNT_W | First element index of the chunk |
| cmd_len_o | output | LEN_W | Element count of the chunk (0 to MAX_VL) |
| vl_o | output | LEN_W | Current vector length, from the last accepted chunk |
| cmp_valid_i | input | 1 | Compare strobe for one element |
| cmp_idx_i | input | IDX_W | Element index whose mask bit is written |
| cmp_elem_i | input | DATA_W | Element value under test |
| cmp_scalar_i | input | DATA_W | Scalar the element is compared with |
| mask_o | output | MAX_VL | Current mask, bit i for element i |
| wr_valid_i | input | 1 | Element write request |
| wr_idx_i | input | IDX_W | Element index of the write |
| wr_data_i | input | DATA_W | Result value for the element |
| wr_en_o | output | 1 | Gated write enable toward the register file |
| wr_idx_o | output | IDX_W | Index of the gated write |
| wr_data_o | output | DATA_W | Data of the gated write |

## Verification
The checks assume the following about the inputs:
- The start pulse lasts one cycle, and `n_i` is meaningful only in that cycle.
- A compare and a write never target the same element in the same cycle. A write in that situation would be gated by the mask bit as it stood before the compare.
- `cmd_ready_i` may stall for any number of cycles.

The stimulus follows these rules:
- Every mask update for a strip completes before the writes for that strip begin.
- Start pulses last one cycle.
- Ready follows either an always-ready pattern or a stall-two-of-three pattern.
- The extra start pulse used for the ignore check arrives only while a loop with several chunks is still in progress.

// File: rtl/strip_pkg.sv
package strip_pkg;

    typedef enum logic [0:0] {
        PL_IDLE  = 1'b0,
        PL_ISSUE = 1'b1
    } plan_state_e;

endpackage

// File: rtl/chunk_planner.sv
module chunk_planner
    import strip_pkg::*;
#(
    parameter int MAX_VL = 64,
    parameter int CNT_W  = 16,
    parameter int LEN_W  = $clog2(MAX_VL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] n_i,
    input  logic             cmd_ready_i,
    output logic             cmd_valid_o,
    output logic [CNT_W-1:0] cmd_base_o,
    output logic [LEN_W-1:0] cmd_len_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [LEN_W-1:0] vl_o
);

    localparam logic [CNT_W-1:0] STRIP_CNT = CNT_W'(MAX_VL);
    localparam logic [LEN_W-1:0] FULL_LEN  = LEN_W'(MAX_VL);

    typedef struct packed {
        plan_state_e      st;
        logic [CNT_W-1:0] base;
        logic [LEN_W-1:0] len;
        logic [CNT_W-1:0] left;   // chunks still to come after the offered one
        logic             done;
        logic [LEN_W-1:0] vl;
    } plan_t;

    plan_t plan_d, plan_q;

    always_comb begin
        plan_d      = plan_q;
        plan_d.done = 1'b0;
        case (plan_q.st)
            PL_IDLE: begin
                if (start_i) begin
                    plan_d.st   = PL_ISSUE;
                    plan_d.base = '0;
                    plan_d.len  = LEN_W'(n_i % STRIP_CNT);
                    plan_d.left = n_i / STRIP_CNT;
                end
            end
            PL_ISSUE: begin
                if (cmd_ready_i) begin
                    plan_d.vl   = plan_q.len;
                    plan_d.base = plan_q.base + CNT_W'(plan_q.len);
                    plan_d.len  = FULL_LEN;
                    if (plan_q.left == '0) begin
                        plan_d.st   = PL_IDLE;
                        plan_d.done = 1'b1;
                    end else begin
                        plan_d.left = plan_q.left - 1'b1;
                    end
                end
            end
            default: plan_d.st = PL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            plan_q <= '{st: PL_IDLE, base: '0, len: '0, left: '0, done: 1'b0, vl: '0};
        end else begin
            plan_q <= plan_d;
        end
    end

    assign cmd_valid_o = (plan_q.st == PL_ISSUE);
    assign busy_o      = (plan_q.st == PL_ISSUE);
    assign cmd_base_o  = plan_q.base;
    assign cmd_len_o   = plan_q.len;
    assign done_o      = plan_q.done;
    assign vl_o        = plan_q.vl;

endmodule

// File: rtl/mask_bank.sv
module mask_bank #(
    parameter int MAX_VL = 64,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(MAX_VL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_valid_i,
    input  logic [IDX_W-1:0]  cmp_idx_i,
    input  logic [DATA_W-1:0] cmp_elem_i,
    input  logic [DATA_W-1:0] cmp_scalar_i,
    output logic [MAX_VL-1:0] mask_o
);

    typedef struct packed {
        logic [MAX_VL-1:0] bits;
    } mask_t;

    mask_t             mask_d, mask_q;
    logic [MAX_VL-1:0] lane_hit;
    logic              differs;

    assign differs = (cmp_elem_i != cmp_scalar_i);

    for (genvar g = 0; g < MAX_VL; g++) begin : g_lane
        assign lane_hit[g] = cmp_valid_i && (cmp_idx_i == IDX_W'(g));
    end

    always_comb begin
        mask_d      = mask_q;
        mask_d.bits = (mask_q.bits & ~lane_hit) | (lane_hit & {MAX_VL{differs}});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '{bits: '0};
        end else begin
            mask_q <= mask_d;
        end
    end

    assign mask_o = mask_q.bits;

endmodule

// File: rtl/write_gate.sv
module write_gate #(
    parameter int MAX_VL = 64,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(MAX_VL),
    parameter int LEN_W  = $clog2(MAX_VL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [MAX_VL-1:0] mask_i,
    input  logic [LEN_W-1:0]  vl_i,
    output logic              wr_en_o,
    output logic [IDX_W-1:0]  wr_idx_o,
    output logic [DATA_W-1:0] wr_data_o
);

    typedef struct packed {
        logic              en;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } gate_t;

    gate_t gate_d, gate_q;
    logic  in_strip;
    logic  lane_on;

    assign in_strip = (LEN_W'(wr_idx_i) < vl_i);
    assign lane_on  = mask_i[wr_idx_i];

    always_comb begin
        gate_d    = gate_q;
        gate_d.en = wr_valid_i && lane_on && in_strip;
        if (wr_valid_i) begin
            gate_d.idx  = wr_idx_i;
            gate_d.data = wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= '{en: 1'b0, idx: '0, data: '0};
        end else begin
            gate_q <= gate_d;
        end
    end

    assign wr_en_o   = gate_q.en;
    assign wr_idx_o  = gate_q.idx;
    assign wr_data_o = gate_q.data;

endmodule

// File: rtl/strip_loop_seq.sv
module strip_loop_seq #(
    parameter int MAX_VL = 64,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(MAX_VL),
    localparam int LEN_W = $clog2(MAX_VL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  n_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              cmd_valid_o,
    input  logic              cmd_ready_i,
    output logic [CNT_W-1:0]  cmd_base_o,
    output logic [LEN_W-1:0]  cmd_len_o,
    output logic [LEN_W-1:0]  vl_o,
    input  logic              cmp_valid_i,
    input  logic [IDX_W-1:0]  cmp_idx_i,
    input  logic [DATA_W-1:0] cmp_elem_i,
    input  logic [DATA_W-1:0] cmp_scalar_i,
    output logic [MAX_VL-1:0] mask_o,
    input  logic              wr_valid_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              wr_en_o,
    output logic [IDX_W-1:0]  wr_idx_o,
    output logic [DATA_W-1:0] wr_data_o
);

    chunk_planner #(
        .MAX_VL (MAX_VL),
        .CNT_W  (CNT_W),
        .LEN_W  (LEN_W)
    ) u_planner (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .n_i         (n_i),
        .cmd_ready_i (cmd_ready_i),
        .cmd_valid_o (cmd_valid_o),
        .cmd_base_o  (cmd_base_o),
        .cmd_len_o   (cmd_len_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .vl_o        (vl_o)
    );

    mask_bank #(
        .MAX_VL (MAX_VL),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_mask (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmp_valid_i  (cmp_valid_i),
        .cmp_idx_i    (cmp_idx_i),
        .cmp_elem_i   (cmp_elem_i),
        .cmp_scalar_i (cmp_scalar_i),
        .mask_o       (mask_o)
    );

    write_gate #(
        .MAX_VL (MAX_VL),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W),
        .LEN_W  (LEN_W)
    ) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid_i (wr_valid_i),
        .wr_idx_i   (wr_idx_i),
        .wr_data_i  (wr_data_i),
        .mask_i     (mask_o),
        .vl_i       (vl_o),
        .wr_en_o    (wr_en_o),
        .wr_idx_o   (wr_idx_o),
        .wr_data_o  (wr_data_o)
    );

endmodule

// File: rtl/strip_loop_seq_chk.sv
module strip_loop_seq_chk #(
    parameter int MAX_VL = 64,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(MAX_VL),
    parameter int LEN_W  = $clog2(MAX_VL + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [CNT_W-1:0]  n_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              cmd_valid_o,
    input logic              cmd_ready_i,
    input logic [CNT_W-1:0]  cmd_base_o,
    input logic [LEN_W-1:0]  cmd_len_o,
    input logic [LEN_W-1:0]  vl_o,
    input logic              cmp_valid_i,
    input logic [IDX_W-1:0]  cmp_idx_i,
    input logic [DATA_W-1:0] cmp_elem_i,
    input logic [DATA_W-1:0] cmp_scalar_i,
    input logic [MAX_VL-1:0] mask_o,
    input logic              wr_valid_i,
    input logic [IDX_W-1:0]  wr_idx_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic              wr_en_o
);

    localparam logic [CNT_W-1:0] STRIP_CNT = CNT_W'(MAX_VL);

    logic             first_q;
    logic [CNT_W-1:0] n_cap_q;
    logic [CNT_W:0]   taken_q;
    logic             shake;

    assign shake = cmd_valid_o && cmd_ready_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= 1'b0;
            n_cap_q <= '0;
            taken_q <= '0;
        end else if (start_i && !busy_o) begin
            first_q <= 1'b1;
            n_cap_q <= n_i;
            taken_q <= '0;
        end else if (shake) begin
            first_q <= 1'b0;
            taken_q <= taken_q + 1'b1;
        end
    end

    p_first_chunk_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && first_q |-> (cmd_len_o == LEN_W'(n_cap_q % STRIP_CNT)) && (cmd_base_o == '0));

    p_full_chunk_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && !first_q |-> cmd_len_o == LEN_W'(MAX_VL));

    p_base_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        shake && busy_o |=> !cmd_valid_o || (cmd_base_o == $past(cmd_base_o) + CNT_W'($past(cmd_len_o))));

    p_chunk_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> taken_q == (CNT_W + 1)'(n_cap_q / STRIP_CNT) + 1'b1);

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_base_o) && $stable(cmd_len_o));

    p_vl_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        shake |=> vl_o == $past(cmd_len_o));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_base_o) && $stable(cmd_len_o));

    p_mask_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid_i |=> mask_o[$past(cmp_idx_i)] == $past(cmp_elem_i != cmp_scalar_i));

    p_write_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_i && mask_o[wr_idx_i] && (LEN_W'(wr_idx_i) < vl_o) |=> wr_en_o);

    p_write_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_i && !(mask_o[wr_idx_i] && (LEN_W'(wr_idx_i) < vl_o)) |=> !wr_en_o);

endmodule

bind strip_loop_seq strip_loop_seq_chk #(
    .MAX_VL (MAX_VL),
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .n_i          (n_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .cmd_valid_o  (cmd_valid_o),
    .cmd_ready_i  (cmd_ready_i),
    .cmd_base_o   (cmd_base_o),
    .cmd_len_o    (cmd_len_o),
    .vl_o         (vl_o),
    .cmp_valid_i  (cmp_valid_i),
    .cmp_idx_i    (cmp_idx_i),
    .cmp_elem_i   (cmp_elem_i),
    .cmp_scalar_i (cmp_scalar_i),
    .mask_o       (mask_o),
    .wr_valid_i   (wr_valid_i),
    .wr_idx_i     (wr_idx_i),
    .wr_data_i    (wr_data_i),
    .wr_en_o      (wr_en_o)
);

// File: tb/strip_loop_seq_bench.sv
module strip_loop_seq_bench;

    localparam int MVL = 64;
    localparam int CW  = 16;
    localparam int DW  = 32;
    localparam int IW  = 6;
    localparam int LW  = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [CW-1:0] n_i = '0;
    logic          busy_o, done_o, cmd_valid_o;
    logic          cmd_ready_i = 1'b0;
    logic [CW-1:0] cmd_base_o;
    logic [LW-1:0] cmd_len_o, vl_o;
    logic          cmp_valid_i = 1'b0;
    logic [IW-1:0] cmp_idx_i = '0;
    logic [DW-1:0] cmp_elem_i = '0, cmp_scalar_i = '0;
    logic [MVL-1:0] mask_o;
    logic          wr_valid_i = 1'b0;
    logic [IW-1:0] wr_idx_i = '0;
    logic [DW-1:0] wr_data_i = '0;
    logic          wr_en_o;
    logic [IW-1:0] wr_idx_o;
    logic [DW-1:0] wr_data_o;

    int checks = 0;
    int failures = 0;
    int x_mem [MVL];

    always #5 clk = ~clk;

    strip_loop_seq #(.MAX_VL(MVL), .CNT_W(CW), .DATA_W(DW)) u_strip_loop_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .n_i(n_i),
        .busy_o(busy_o), .done_o(done_o), .cmd_valid_o(cmd_valid_o),
        .cmd_ready_i(cmd_ready_i), .cmd_base_o(cmd_base_o), .cmd_len_o(cmd_len_o),
        .vl_o(vl_o), .cmp_valid_i(cmp_valid_i), .cmp_idx_i(cmp_idx_i),
        .cmp_elem_i(cmp_elem_i), .cmp_scalar_i(cmp_scalar_i), .mask_o(mask_o),
        .wr_valid_i(wr_valid_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
        .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic test_reset();
        check(cmd_valid_o == 1'b0, "R6 reset valid", cmd_valid_o, 0);
        check(busy_o == 1'b0 && done_o == 1'b0, "R6 reset busy/done", {busy_o, done_o}, 0);
        check(vl_o == '0, "R5 reset vl", vl_o, 0);
        check(mask_o == '0, "R8 reset mask", longint'(mask_o[31:0]), 0);
        check(wr_en_o == 1'b0, "R9 reset wr_en", wr_en_o, 0);
    endtask

    // Runs one loop; stall: ready two cycles out of three low; poke: extra start mid-loop (R7).
    task automatic run_loop(input int n, input bit stall, input bit poke);
        int cnt = n / MVL + 1;
        int k = 0;
        int cyc = 0;
        bit held = 1'b0;
        int held_base = 0;
        int held_len = 0;
        int exp_len, exp_base;
        @(negedge clk);
        start_i = 1'b1;
        n_i = CW'(n);
        @(negedge clk);
        start_i = 1'b0;
        while (k < cnt && cyc < 5000) begin
            cmd_ready_i = stall ? (cyc % 3 == 2) : 1'b1;
            exp_len  = (k == 0) ? (n % MVL) : MVL;
            exp_base = (k == 0) ? 0 : (n % MVL) + (k - 1) * MVL;
            if (held) begin
                check(cmd_valid_o && int'(cmd_base_o) == held_base && int'(cmd_len_o) == held_len,
                      "R4 held command", cmd_base_o, held_base);
                held = 1'b0;
            end
            if (cmd_valid_o && cmd_ready_i) begin
                check(int'(cmd_len_o) == exp_len, k == 0 ? "R1 first len" : "R2 later len", cmd_len_o, exp_len);
                check(int'(cmd_base_o) == exp_base, k == 0 ? "R1 first base" : "R2 later base", cmd_base_o, exp_base);
                if (poke && k == 0) begin
                    start_i = 1'b1;
                    n_i = CW'(7);
                end
                @(negedge clk);
                cyc++;
                if (poke && k == 0) begin
                    start_i = 1'b0;
                    check(busy_o == 1'b1, "R7 start ignored busy", busy_o, 1);
                end
                check(int'(vl_o) == exp_len, "R5 vl after accept", vl_o, exp_len);
                k++;
                if (k == cnt) begin
                    check(done_o == 1'b1 && busy_o == 1'b0, "R6 done pulse", done_o, 1);
                    cmd_ready_i = 1'b0;
                    @(negedge clk);
                    check(done_o == 1'b0, "R6 done one cycle", done_o, 0);
                    check(cmd_valid_o == 1'b0, "R3 no extra chunk", cmd_valid_o, 0);
                end
            end else begin
                check(cmd_valid_o == 1'b1, "R3 chunk offered", cmd_valid_o, 1);
                if (cmd_valid_o) begin
                    held = 1'b1;
                    held_base = int'(cmd_base_o);
                    held_len = int'(cmd_len_o);
                end
                @(negedge clk);
                cyc++;
            end
        end
        check(k == cnt, "R3 chunk count", k, cnt);
    endtask

    // Compare elements lo..hi against zero, then masked writes of x-y; expects vl as given.
    task automatic mask_and_write(input int vl, input int lo, input int hi);
        int xv [MVL];
        bit mexp [MVL];
        int prev = -1;
        for (int i = lo; i <= hi; i++) begin
            xv[i] = (i % 3 == 0) ? 0 : i * 5 + 1;
            mexp[i] = (xv[i] != 0);
            x_mem[i] = xv[i];
        end
        check(int'(vl_o) == vl, "R5 vl before mask test", vl_o, vl);
        for (int i = lo; i <= hi; i++) begin
            @(negedge clk);
            cmp_valid_i = 1'b1;
            cmp_idx_i = IW'(i);
            cmp_elem_i = DW'(xv[i]);
            cmp_scalar_i = '0;
        end
        @(negedge clk);
        cmp_valid_i = 1'b0;
        for (int i = lo; i <= hi; i++) begin
            check(mask_o[i] == mexp[i], "R8 mask bit", mask_o[i], mexp[i]);
        end
        for (int i = lo; i <= hi + 1; i++) begin
            if (prev >= 0) begin
                bit want = mexp[prev] && (prev < vl);
                check(wr_en_o == want, want ? "R9 write passes" : "R10 write blocked", wr_en_o, want);
                if (wr_en_o) begin
                    check(int'(wr_idx_o) == prev && int'(wr_data_o) == xv[prev] - prev,
                          "R9 write fields", wr_data_o, xv[prev] - prev);
                    x_mem[wr_idx_o] = int'(wr_data_o);
                end
            end
            if (i <= hi) begin
                wr_valid_i = 1'b1;
                wr_idx_i = IW'(i);
                wr_data_i = DW'(xv[i] - i);
                prev = i;
            end else begin
                wr_valid_i = 1'b0;
            end
            @(negedge clk);
        end
        for (int i = lo; i <= hi; i++) begin
            int want = (mexp[i] && i < vl) ? xv[i] - i : xv[i];
            check(x_mem[i] == want, "R10 element kept/updated", x_mem[i], want);
        end
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        run_loop(130, 1'b0, 1'b0);   // R1 R2 R3: remainder 2 then two full strips
        run_loop(128, 1'b0, 1'b0);   // R1 R3: exact multiple, zero-length first chunk
        run_loop(0, 1'b0, 1'b0);     // R3: single zero-length chunk
        run_loop(70, 1'b1, 1'b0);    // R4: stalled handshake
        run_loop(200, 1'b0, 1'b1);   // R7: start ignored mid-loop
        run_loop(5, 1'b0, 1'b0);     // single short chunk, vl = 5
        mask_and_write(5, 0, 9);     // R8 R9 R10 incl. beyond vl
        run_loop(64, 1'b0, 1'b0);    // vl ends at 64
        mask_and_write(64, 56, 63);  // R9 at top lane
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule